// File: doc/BRIEF.md
# Parallel I/O Port with Staged Output

This block is an 8-bit general-purpose parallel port that sits on a simple synchronous internal I/O bus. The bus carries an 8-bit address, a write strobe, a read strobe, and separate 8-bit write and read data. Software writes output data into a staging (preload) register. The data moves from there into the output register that drives the pins. Each 4-bit nibble has its own rule for when that move happens. It can happen in the same cycle as the load, or it can wait for one of three external transfer-event pulses. That wait lets several ports change their outputs together at a hardware-timed instant.

Each pin has a direction bit, which acts as its output enable, and a function bit. The function bit swaps the pin's data for an externally generated I/O strobe. Eight dedicated addresses each set or clear one output bit, so software can change a single pin without a read-modify-write. A read of the data address returns the live pin levels. A pin that is not driven takes its level from a pad-input port.

Top module: `gpio_preload_port`

## Requirements
- R1: While reset is asserted, all direction and function bits are 0 (`pad_oe` = 0x00), and both nibble transfer codes are 00.
- R2: A write to address 0x77 sets the direction bits, and `pad_oe` follows them one clock edge after the write. A 1 bit means the pin is an output.
- R3: A write to address 0x70 loads the preload register. For a nibble whose transfer code is 00, `pad_out` shows the new nibble one clock edge after the write.
- R4: For a nibble whose transfer code is 01, 10 or 11, the output register holds its value across preload writes. On a clock edge where `xfer_evt[code-1]` is 1, it copies the nibble's current preload value. Events that are not selected have no effect.
- R5: Address 0x74 sets the transfer codes. Bits 1:0 give the low-nibble code and bits 5:4 give the high-nibble code. Each nibble follows only its own code. Writing 0x74 does not move any data by itself.
- R6: A write to address 0x78+i (i = 0..7) sets preload bit i to `bus_wdata[0]` and leaves the other seven bits unchanged. The nibble that holds bit i then follows the same transfer rule as in R3 and R4.
- R7: A write to address 0x75 sets the function bits. Where a function bit is 1, `pad_out[i]` follows `strobe_in[i]` combinationally in place of the output register bit.
- R8: A read of address 0x70 returns, one clock edge later on `bus_rdata`, each pin's level. For an output pin that level is `pad_out[i]`; for an input pin it is `pad_in[i]`.
- R9: A read of any other address, including the write-only ones, returns 0x00 and changes no state.
- R10: Control bits 7:6 and 3:2 are ignored. Writing them has no effect on the transfer behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| strobe_in | input | 8 | Alternate I/O strobe for each pin |
| xfer_evt | input | 3 | Transfer-event pulses, selected by codes 01/10/11 |
| pad_in | input | 8 | Level driven onto the pins from outside |
| pad_out | output | 8 | Pin output data |
| pad_oe | output | 8 | Pin output enable |

## Verification
Register writes, single-bit writes and transfer events all change `pad_out` and `pad_oe` at the clock edge on which they are sampled. Read data lands in the `bus_rdata` register at that same edge. The strobe substitution, by contrast, is combinational. The bench therefore drives each access or event half a cycle before an edge. It then compares every output at the next falling edge, which falls between that edge and the following one. For the strobe path it changes `strobe_in` and compares after a settling delay, with no clock edge in between.

// File: rtl/gpp_pkg.sv
package gpp_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned NUM_NIB   = PORT_W / NIB_W;
  localparam int unsigned NUM_EVT   = 3;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned BIT_IDX_W = $clog2(PORT_W);

  localparam logic [ADDR_W-1:0] A_DATA = 8'h70;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h74;
  localparam logic [ADDR_W-1:0] A_FUNC = 8'h75;
  localparam logic [ADDR_W-1:0] A_DIR  = 8'h77;
  localparam logic [ADDR_W-1:0] A_BIT0 = 8'h78;

  typedef logic [SEL_W-1:0] xsel_t;
endpackage

// File: rtl/gpp_regs.sv
module gpp_regs
  import gpp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [PORT_W-1:0]              wdata,
  input  logic [PORT_W-1:0]              pin_val,
  output logic [PORT_W-1:0]              dir_q,
  output logic [PORT_W-1:0]              func_q,
  output xsel_t [NUM_NIB-1:0]            sel_q,
  output logic [PORT_W-1:0]              pre_q,
  output logic [PORT_W-1:0]              pre_nxt,
  output logic [NUM_NIB-1:0]             nib_ld,
  output logic [PORT_W-1:0]              rdata_q
);
  localparam int unsigned BIT_BLK_W = ADDR_W - BIT_IDX_W;

  logic hit_data, hit_ctrl, hit_func, hit_dir, hit_bit;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 pre_en;
  xsel_t [NUM_NIB-1:0]  sel_nxt;
  logic [PORT_W-1:0]    rdata_nxt;

  assign hit_data = (addr == A_DATA);
  assign hit_ctrl = (addr == A_CTRL);
  assign hit_func = (addr == A_FUNC);
  assign hit_dir  = (addr == A_DIR);
  assign hit_bit  = (addr[ADDR_W-1:BIT_IDX_W] == A_BIT0[ADDR_W-1:BIT_IDX_W]);
  assign bit_idx  = addr[BIT_IDX_W-1:0];

  // Staging register next value and per-nibble load flags
  always_comb begin
    pre_nxt = pre_q;
    nib_ld  = '0;
    if (wr && hit_data) begin
      pre_nxt = wdata;
      nib_ld  = '1;
    end else if (wr && hit_bit) begin
      pre_nxt[bit_idx]                       = wdata[0];
      nib_ld[bit_idx / BIT_IDX_W'(NIB_W)]    = 1'b1;
    end
  end
  assign pre_en = |nib_ld;

  // Preload is deliberately left without reset
  always_ff @(posedge clk) begin
    if (pre_en) pre_q <= pre_nxt;
  end

  generate
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_sel
      assign sel_nxt[n] = wdata[n*NIB_W +: SEL_W];
    end
  endgenerate

  always_comb begin
    rdata_nxt = '0;
    if (rd && hit_data) rdata_nxt = pin_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      func_q  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && hit_dir)  dir_q  <= wdata;
      if (wr && hit_func) func_q <= wdata;
      if (wr && hit_ctrl) sel_q  <= sel_nxt;
      rdata_q <= rdata_nxt;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dir_q == '0 && func_q == '0 && sel_q == '0));

  // R9
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_data) |=> (rdata_q == '0));

  // R6
  bit_write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_bit) |=>
      (((pre_q ^ $past(pre_q)) & ~(PORT_W'(1) << $past(bit_idx))) == '0));

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_dir) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpp_nib_out.sv
module gpp_nib_out
  import gpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  xsel_t             sel,
  input  logic              ld,
  input  logic [NIB_W-1:0]  pre_nxt,
  input  logic [NIB_W-1:0]  pre_cur,
  input  logic [NUM_EVT-1:0] evt,
  output logic [NIB_W-1:0]  out_q
);
  logic [NUM_EVT:0]   evt_ext;
  logic               imm_mode, evt_hit, out_en;
  logic [NIB_W-1:0]   out_nxt;

  assign evt_ext  = {evt, 1'b0};
  assign imm_mode = (sel == '0);
  assign evt_hit  = evt_ext[sel];

  always_comb begin
    out_en  = 1'b0;
    out_nxt = out_q;
    if (imm_mode && ld) begin
      out_en  = 1'b1;
      out_nxt = pre_nxt;
    end else if (evt_hit) begin
      out_en  = 1'b1;
      out_nxt = pre_cur;
    end
  end

  // Output register is not reset, like the staging register
  always_ff @(posedge clk) begin
    if (out_en) out_q <= out_nxt;
  end

  // R4
  hold_without_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_mode && !evt_hit) |=> $stable(out_q));

  // R4
  event_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_mode && evt_hit) |=> (out_q == $past(pre_cur)));

  // R3
  immediate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_mode && ld) |=> (out_q == $past(pre_nxt)));
endmodule

// File: rtl/gpp_pins.sv
module gpp_pins
  import gpp_pkg::*;
(
  input  logic [PORT_W-1:0] out_q,
  input  logic [PORT_W-1:0] func,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] strobe,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pin_val
);
  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign pad_out[i] = func[i] ? strobe[i] : out_q[i];
      assign pad_oe[i]  = dir[i];
      assign pin_val[i] = dir[i] ? pad_out[i] : pad_in[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_preload_port.sv
module gpio_preload_port
  import gpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        strobe_in,
  input  logic [2:0]        xfer_evt,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe
);
  logic [1:0]            rst_sync;
  logic                  rst_i;
  logic [PORT_W-1:0]     dir_q, func_q, pre_q, pre_nxt, out_q, pin_val;
  xsel_t [NUM_NIB-1:0]   sel_q;
  logic [NUM_NIB-1:0]    nib_ld;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  gpp_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_i),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .pin_val (pin_val),
    .dir_q   (dir_q),
    .func_q  (func_q),
    .sel_q   (sel_q),
    .pre_q   (pre_q),
    .pre_nxt (pre_nxt),
    .nib_ld  (nib_ld),
    .rdata_q (bus_rdata)
  );

  generate
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
      gpp_nib_out u_nib (
        .clk     (clk),
        .rst_n   (rst_i),
        .sel     (sel_q[n]),
        .ld      (nib_ld[n]),
        .pre_nxt (pre_nxt[n*NIB_W +: NIB_W]),
        .pre_cur (pre_q[n*NIB_W +: NIB_W]),
        .evt     (xfer_evt),
        .out_q   (out_q[n*NIB_W +: NIB_W])
      );
    end
  endgenerate

  gpp_pins u_pins (
    .out_q   (out_q),
    .func    (func_q),
    .dir     (dir_q),
    .strobe  (strobe_in),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pin_val (pin_val)
  );
endmodule

// File: tb/gpio_preload_port_tb.sv
module gpio_preload_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] strobe_in = '0;
  logic [2:0] xfer_evt = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_preload_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strobe_in(strobe_in), .xfer_evt(xfer_evt), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {req[56:53], kind[52:51] 0=wr 1=rd 2=evt, addr, data, evt, pad_in, exp_out, exp_oe, exp_rd}
  localparam int NV = 19;
  localparam logic [56:0] VEC [NV] = '{
    {4'd3,  2'd0, 8'h70, 8'hA5, 3'b000, 8'h00, 8'hA5, 8'h00, 8'h00}, // R3 immediate after reset
    {4'd2,  2'd0, 8'h77, 8'hFF, 3'b000, 8'h00, 8'hA5, 8'hFF, 8'h00}, // R2
    {4'd8,  2'd1, 8'h70, 8'h00, 3'b000, 8'h00, 8'hA5, 8'hFF, 8'hA5}, // R8 all outputs
    {4'd2,  2'd0, 8'h77, 8'h0F, 3'b000, 8'h00, 8'hA5, 8'h0F, 8'h00}, // R2
    {4'd8,  2'd1, 8'h70, 8'h00, 3'b000, 8'h3C, 8'hA5, 8'h0F, 8'h35}, // R8 mixed
    {4'd2,  2'd0, 8'h77, 8'hFF, 3'b000, 8'h00, 8'hA5, 8'hFF, 8'h00}, // R2
    {4'd5,  2'd0, 8'h74, 8'h21, 3'b000, 8'h00, 8'hA5, 8'hFF, 8'h00}, // R5 codes 01/10
    {4'd4,  2'd0, 8'h70, 8'h3C, 3'b000, 8'h00, 8'hA5, 8'hFF, 8'h00}, // R4 held
    {4'd5,  2'd2, 8'h00, 8'h00, 3'b001, 8'h00, 8'hAC, 8'hFF, 8'h00}, // R5 low only
    {4'd4,  2'd2, 8'h00, 8'h00, 3'b100, 8'h00, 8'hAC, 8'hFF, 8'h00}, // R4 unselected
    {4'd4,  2'd2, 8'h00, 8'h00, 3'b010, 8'h00, 8'h3C, 8'hFF, 8'h00}, // R4 high
    {4'd6,  2'd0, 8'h79, 8'h01, 3'b000, 8'h00, 8'h3C, 8'hFF, 8'h00}, // R6 held by code
    {4'd6,  2'd2, 8'h00, 8'h00, 3'b001, 8'h00, 8'h3E, 8'hFF, 8'h00}, // R6 then event
    {4'd5,  2'd0, 8'h74, 8'h00, 3'b000, 8'h00, 8'h3E, 8'hFF, 8'h00}, // R5 no data move
    {4'd6,  2'd0, 8'h7E, 8'h01, 3'b000, 8'h00, 8'h7E, 8'hFF, 8'h00}, // R6 set bit6
    {4'd6,  2'd0, 8'h7C, 8'hFE, 3'b000, 8'h00, 8'h6E, 8'hFF, 8'h00}, // R6 clear bit4 from d[0]
    {4'd9,  2'd1, 8'h75, 8'h00, 3'b000, 8'h00, 8'h6E, 8'hFF, 8'h00}, // R9
    {4'd9,  2'd1, 8'h77, 8'h00, 3'b000, 8'h00, 8'h6E, 8'hFF, 8'h00}, // R9
    {4'd7,  2'd0, 8'h75, 8'h81, 3'b000, 8'h00, 8'h6E, 8'hFF, 8'h00}  // R7 strobe low
  };

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] kind, input logic [7:0] a,
                        input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = (kind == 2'd0);
    bus_rd    = (kind == 2'd1);
    xfer_evt  = e;
    @(posedge clk);
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_rd   = 1'b0;
    xfer_evt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state observed while reset is held
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "pad_oe in reset", pad_oe, 8'h00);
    chk("R1", "rdata in reset", bus_rdata, 8'h00);
    do_reset();

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v][56:53], v);
      pad_in = VEC[v][31:24];
      access(VEC[v][52:51], VEC[v][50:43], VEC[v][42:35], VEC[v][34:32]);
      chk(tag, "pad_out", pad_out, VEC[v][23:16]);
      chk(tag, "pad_oe", pad_oe, VEC[v][15:8]);
      if (VEC[v][52:51] == 2'd1) chk(tag, "rdata", bus_rdata, VEC[v][7:0]);
    end

    // R7 strobe substitution is combinational
    strobe_in = 8'hFF;
    #2;
    chk("R7", "strobe high", pad_out, 8'hEF);
    strobe_in = 8'h01;
    #2;
    chk("R7", "strobe bit0", pad_out, 8'h6F);

    // R8 input pin shows pad_in while bit0 still shows strobe
    strobe_in = 8'hFF;
    access(2'd0, 8'h77, 8'h7F, 3'b000);
    pad_in = 8'h00;
    access(2'd1, 8'h70, 8'h00, 3'b000);
    chk("R8", "read mixed strobe", bus_rdata, 8'h6F);

    // R10 ignored control bits leave both nibbles immediate
    access(2'd0, 8'h75, 8'h00, 3'b000);
    access(2'd0, 8'h74, 8'hCC, 3'b000);
    access(2'd0, 8'h70, 8'h12, 3'b000);
    chk("R10", "ignored ctrl bits", pad_out, 8'h12);

    // R9 read of bit address has no side effect on outputs
    access(2'd1, 8'h7A, 8'h00, 3'b000);
    chk("R9", "read bit addr", bus_rdata, 8'h00);
    chk("R9", "no side effect", pad_out, 8'h12);

    // R4 event and write in same cycle copies the old preload
    access(2'd0, 8'h74, 8'h03, 3'b000);
    access(2'd0, 8'h70, 8'h9B, 3'b100);
    chk("R4", "same-cycle write+event", pad_out, 8'h92);
    access(2'd2, 8'h00, 8'h00, 3'b100);
    chk("R4", "event after write", pad_out, 8'h9B);

    // R1 reset mid-run clears direction, function and codes
    access(2'd0, 8'h75, 8'hFF, 3'b000);
    do_reset();
    @(negedge clk);
    chk("R1", "pad_oe after reset", pad_oe, 8'h00);
    access(2'd0, 8'h77, 8'hFF, 3'b000);
    access(2'd0, 8'h70, 8'h55, 3'b000);
    chk("R1", "func and codes cleared", pad_out, 8'h55);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule